// File: doc/BRIEF.md
# ADC Result Averaging, Offset and Window Compare Unit

This block sits between a 12-bit successive-approximation converter and the register that holds its result. Each raw sample arrives with a one-cycle valid strobe. The block can accumulate a set of 4, 8, 16 or 32 samples and reduce the set to a truncated average. It then applies a signed-direction offset with saturation. Finally it checks the value against a two-threshold window, which has four selectable meanings.

A processed value is written into the result register, and the completion flag is raised, only when the averaging set is complete and the window test (if enabled) passes. When overwrite is disabled, a value that arrives while the flag is still set is discarded. An acknowledge input clears the flag. A single-cycle request pulse can be issued on each commit so that a transfer engine can collect the result.

Top module: `adcpp_top`

## Requirements
- R1: After reset the result is 0, the completion flag is 0 and the request pulse is 0.
- R2: With avg_sel set to 4, 5, 6 or 7, averaging is off. Each valid sample is processed, and it is committed in the cycle that follows its strobe.
- R3: With avg_sel set to 0, 1, 2 or 3, sets of 4, 8, 16 or 32 samples are used. Nothing is committed before the last sample of a set arrives. The committed value is the sum of the set shifted right by log2 of the set size, truncated.
- R4: With ofs_sub at 0, ofs_value is added to the value, and the sum saturates at 4095.
- R5: With ofs_sub at 1, ofs_value is subtracted from the value, and the difference saturates at 0.
- R6: Window tests use the value after the offset. Mode 0 passes when the value is below thr_a. Mode 1 passes when the value is at least thr_a.
- R7: Mode 2 passes when the value is below thr_a OR above thr_b if thr_a <= thr_b. It passes when the value is below thr_a AND above thr_b if thr_a > thr_b.
- R8: Mode 3 passes when thr_a <= value <= thr_b if thr_a <= thr_b. It passes when the value is at least thr_a OR at most thr_b if thr_a > thr_b.
- R9: With cmp_en at 1, a failing value leaves the result and the flag unchanged and raises no request. A completed averaging set is still consumed.
- R10: With ovr_en at 0, a value that would be committed while the flag is set is dropped. The result stays unchanged.
- R11: With ovr_en at 1, a new committed value replaces the stored one even while the flag is set.
- R12: flag_ack clears the flag in the following cycle. If a commit happens in the same cycle as flag_ack, the commit wins: the flag stays set and the result takes the new value.
- R13: With dma_en at 1, dma_req pulses high for exactly one cycle, in the cycle in which a commit becomes visible. With dma_en at 0, dma_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_valid | input | 1 | Raw sample strobe |
| raw_data | input | 12 | Raw converter sample |
| avg_sel | input | 3 | Averaging code: 0..3 gives 4/8/16/32 samples, 4..7 turns averaging off |
| ofs_value | input | 12 | Offset magnitude |
| ofs_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| cmp_en | input | 1 | Enables the window test |
| cmp_mode | input | 2 | Window test mode, 0..3 |
| thr_a | input | 12 | First threshold |
| thr_b | input | 12 | Second threshold |
| ovr_en | input | 1 | Allows a new value to overwrite an unacknowledged one |
| dma_en | input | 1 | Enables the request pulse |
| flag_ack | input | 1 | Clears the completion flag |
| result | output | 12 | Committed result |
| done_flag | output | 1 | Completion flag |
| dma_req | output | 1 | One-cycle request per commit |

## Verification
A wrong sample counter or a wrong accumulator shows up at the ports only at the end of a set. The flag then rises one sample early or late, or the averaged value is off. Each averaging depth therefore gets a run that checks the flag before and after the final sample. A wrong window or offset decision shows one cycle after the strobe, either as a result that should have stayed unchanged or as a flag that is missing. Thresholds are placed exactly on the window edges in both threshold orderings. A stuck flag or a stuck request pulse is caught by the acknowledge checks and the overwrite checks that follow every commit.

// File: rtl/adcpp_pkg.sv
package adcpp_pkg;
  localparam int RES_W     = 12;
  localparam int LOG_MAX   = 5;
  localparam int AVG_SEL_W = 3;

  typedef enum logic [1:0] {
    CMP_BELOW   = 2'd0,
    CMP_ATLEAST = 2'd1,
    CMP_OUTSIDE = 2'd2,
    CMP_INSIDE  = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/adcpp_avg.sv
module adcpp_avg #(
  parameter int DATA_W  = 12,
  parameter int LOG_MAX = 5,
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SEL_W-1:0]  avg_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int ACC_W = DATA_W + LOG_MAX;
  localparam int CNT_W = LOG_MAX;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             avg_on, last;
  int unsigned      shift;

  always_comb begin
    avg_on = (int'(avg_sel) + 2) <= LOG_MAX;
    shift  = int'(avg_sel) + 2;
    sum    = acc_q + ACC_W'(in_data);
    last   = avg_on && (cnt_q == CNT_W'((1 << shift) - 1));
    out_valid = in_valid && (!avg_on || last);
    out_data  = avg_on ? DATA_W'(sum >> shift) : in_data;
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (!avg_on) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (in_valid) begin
      if (last) begin
        cnt_d = '0;
        acc_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  // R3: a finished set restarts the counter
  a_r3_set_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && avg_on) |=> (cnt_q == '0));
  // R2: with averaging off no partial set is held
  a_r2_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_on |=> (acc_q == '0));
endmodule

// File: rtl/adcpp_offset.sv
module adcpp_offset #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] ofs_value,
  input  logic              ofs_sub,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, in_data} + {1'b0, ofs_value};
    if (ofs_sub) begin
      out_data = (in_data < ofs_value) ? '0 : (in_data - ofs_value);
    end else begin
      out_data = wide_sum[DATA_W] ? '1 : wide_sum[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/adcpp_window.sv
module adcpp_window
  import adcpp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] thr_a,
  input  logic [DATA_W-1:0] thr_b,
  input  logic [1:0]        mode,
  output logic              hit
);
  logic below_a, above_b, ordered;

  always_comb begin
    below_a = value < thr_a;
    above_b = value > thr_b;
    ordered = thr_a <= thr_b;
    case (cmp_mode_e'(mode))
      CMP_BELOW:   hit = below_a;
      CMP_ATLEAST: hit = !below_a;
      CMP_OUTSIDE: hit = ordered ? (below_a || above_b) : (below_a && above_b);
      default:     hit = ordered ? (!below_a && !above_b) : (!below_a || !above_b);
    endcase
  end
endmodule

// File: rtl/adcpp_top.sv
module adcpp_top
  import adcpp_pkg::*;
#(
  parameter int DATA_W  = RES_W,
  parameter int AVG_LOG = LOG_MAX,
  parameter int SEL_W   = AVG_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [SEL_W-1:0]  avg_sel,
  input  logic [DATA_W-1:0] ofs_value,
  input  logic              ofs_sub,
  input  logic              cmp_en,
  input  logic [1:0]        cmp_mode,
  input  logic [DATA_W-1:0] thr_a,
  input  logic [DATA_W-1:0] thr_b,
  input  logic              ovr_en,
  input  logic              dma_en,
  input  logic              flag_ack,
  output logic [DATA_W-1:0] result,
  output logic              done_flag,
  output logic              dma_req
);
  logic              avg_valid;
  logic [DATA_W-1:0] avg_data, ofs_data;
  logic              win_hit, accept;
  logic [DATA_W-1:0] result_q, result_d;
  logic              flag_q, flag_d, dma_q, dma_d;

  adcpp_avg #(.DATA_W(DATA_W), .LOG_MAX(AVG_LOG), .SEL_W(SEL_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .in_valid(raw_valid), .in_data(raw_data),
    .avg_sel(avg_sel), .out_valid(avg_valid), .out_data(avg_data));

  adcpp_offset #(.DATA_W(DATA_W)) u_ofs (
    .in_data(avg_data), .ofs_value(ofs_value), .ofs_sub(ofs_sub),
    .out_data(ofs_data));

  adcpp_window #(.DATA_W(DATA_W)) u_win (
    .value(ofs_data), .thr_a(thr_a), .thr_b(thr_b), .mode(cmp_mode),
    .hit(win_hit));

  always_comb begin
    accept   = avg_valid && (!cmp_en || win_hit) && (ovr_en || !flag_q);
    result_d = accept ? ofs_data : result_q;
    flag_d   = accept || (flag_q && !flag_ack);
    dma_d    = accept && dma_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flag_q   <= 1'b0;
      dma_q    <= 1'b0;
    end else begin
      if (accept) result_q <= result_d;
      flag_q <= flag_d;
      dma_q  <= dma_d;
    end
  end

  assign result    = result_q;
  assign done_flag = flag_q;
  assign dma_req   = dma_q;

  // R13: every request accompanies a set flag
  a_r13_req_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> done_flag);
  // R10: a held flag protects the stored value
  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !ovr_en) |=> $stable(result));
  // R9: a failing window test changes nothing
  a_r9_miss_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_valid && cmp_en && !win_hit && !flag_ack) |=> ($stable(done_flag) && $stable(result)));
  // R12: acknowledge without a commit clears the flag
  a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ack && !avg_valid) |=> !done_flag);
  // R2: the flag can only rise after a sample strobe
  a_r2_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(raw_valid));
endmodule

// File: tb/adcpp_top_bench.sv
module adcpp_top_bench;
  typedef struct packed {
    logic [11:0] raw;
    logic [11:0] ofs;
    logic        sub;
    logic [1:0]  mode;
    logic [11:0] a;
    logic [11:0] b;
    logic        hit;
    logic [11:0] res;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{12'd100,  12'd0,   1'b0, 2'd0, 12'd200, 12'd0,   1'b1, 12'd100},
    '{12'd300,  12'd0,   1'b0, 2'd0, 12'd200, 12'd0,   1'b0, 12'd100},
    '{12'd200,  12'd0,   1'b0, 2'd1, 12'd200, 12'd0,   1'b1, 12'd200},
    '{12'd199,  12'd0,   1'b0, 2'd1, 12'd200, 12'd0,   1'b0, 12'd200},
    '{12'd50,   12'd0,   1'b0, 2'd2, 12'd100, 12'd300, 1'b1, 12'd50},
    '{12'd200,  12'd0,   1'b0, 2'd2, 12'd100, 12'd300, 1'b0, 12'd50},
    '{12'd301,  12'd0,   1'b0, 2'd2, 12'd100, 12'd300, 1'b1, 12'd301},
    '{12'd200,  12'd0,   1'b0, 2'd2, 12'd300, 12'd100, 1'b1, 12'd200},
    '{12'd100,  12'd0,   1'b0, 2'd2, 12'd300, 12'd100, 1'b0, 12'd200},
    '{12'd100,  12'd0,   1'b0, 2'd3, 12'd100, 12'd300, 1'b1, 12'd100},
    '{12'd301,  12'd0,   1'b0, 2'd3, 12'd100, 12'd300, 1'b0, 12'd100},
    '{12'd200,  12'd0,   1'b0, 2'd3, 12'd300, 12'd100, 1'b0, 12'd100},
    '{12'd50,   12'd0,   1'b0, 2'd3, 12'd300, 12'd100, 1'b1, 12'd50},
    '{12'd4000, 12'd200, 1'b0, 2'd1, 12'd0,   12'd0,   1'b1, 12'd4095},
    '{12'd1000, 12'd234, 1'b0, 2'd1, 12'd0,   12'd0,   1'b1, 12'd1234},
    '{12'd100,  12'd300, 1'b1, 2'd1, 12'd0,   12'd0,   1'b1, 12'd0},
    '{12'd1000, 12'd1,   1'b1, 2'd1, 12'd0,   12'd0,   1'b1, 12'd999},
    '{12'd150,  12'd100, 1'b0, 2'd0, 12'd200, 12'd0,   1'b0, 12'd999}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw_valid = 1'b0;
  logic [11:0] raw_data = '0;
  logic [2:0]  avg_sel = 3'd4;
  logic [11:0] ofs_value = '0;
  logic        ofs_sub = 1'b0;
  logic        cmp_en = 1'b0;
  logic [1:0]  cmp_mode = '0;
  logic [11:0] thr_a = '0;
  logic [11:0] thr_b = '0;
  logic        ovr_en = 1'b1;
  logic        dma_en = 1'b0;
  logic        flag_ack = 1'b0;
  logic [11:0] result;
  logic        done_flag, dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adcpp_top u_adcpp_top (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
    .avg_sel(avg_sel), .ofs_value(ofs_value), .ofs_sub(ofs_sub),
    .cmp_en(cmp_en), .cmp_mode(cmp_mode), .thr_a(thr_a), .thr_b(thr_b),
    .ovr_en(ovr_en), .dma_en(dma_en), .flag_ack(flag_ack),
    .result(result), .done_flag(done_flag), .dma_req(dma_req));

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] d);
    @(negedge clk);
    raw_data  = d;
    raw_valid = 1'b1;
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    flag_ack = 1'b1;
    @(negedge clk);
    flag_ack = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result", result, 12'd0);
    check("R1 flag", {11'd0, done_flag}, 12'd0);
    check("R1 dma", {11'd0, dma_req}, 12'd0);

    // table: averaging off, compare on, overwrite on, requests on (R2, R4-R8)
    cmp_en = 1'b1;
    dma_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      ack();
      ofs_value = VT[i].ofs;
      ofs_sub   = VT[i].sub;
      cmp_mode  = VT[i].mode;
      thr_a     = VT[i].a;
      thr_b     = VT[i].b;
      send(VT[i].raw);
      check($sformatf("R6/R7/R8/R4/R5 vec %0d result", i), result, VT[i].res);
      check($sformatf("R9 vec %0d flag", i), {11'd0, done_flag}, {11'd0, VT[i].hit});
      check($sformatf("R13 vec %0d dma", i), {11'd0, dma_req}, {11'd0, VT[i].hit});
    end
    @(negedge clk);
    check("R13 pulse ends", {11'd0, dma_req}, 12'd0);

    // R2: code 7 also means averaging off
    ofs_value = '0; ofs_sub = 1'b0; cmp_en = 1'b0; dma_en = 1'b0;
    avg_sel = 3'd7;
    ack();
    send(12'd77);
    check("R2 code7 result", result, 12'd77);
    check("R2 code7 flag", {11'd0, done_flag}, 12'd1);

    // R3: four-sample set
    avg_sel = 3'd0;
    ack();
    send(12'd10); send(12'd11); send(12'd12);
    check("R3 x4 early flag", {11'd0, done_flag}, 12'd0);
    check("R3 x4 early result", result, 12'd77);
    send(12'd13);
    check("R3 x4 result", result, 12'd11);
    check("R3 x4 flag", {11'd0, done_flag}, 12'd1);

    // R3: eight samples of full scale
    avg_sel = 3'd1;
    ack();
    for (int i = 0; i < 8; i++) send(12'd4095);
    check("R3 x8 result", result, 12'd4095);

    // R3: sixteen samples 1..16
    avg_sel = 3'd2;
    ack();
    for (int i = 1; i <= 16; i++) send(12'(i));
    check("R3 x16 result", result, 12'd8);

    // R3: thirty-two samples i*100
    avg_sel = 3'd3;
    ack();
    for (int i = 0; i < 31; i++) send(12'(i * 100));
    check("R3 x32 early flag", {11'd0, done_flag}, 12'd0);
    send(12'd3100);
    check("R3 x32 result", result, 12'd1550);
    check("R3 x32 flag", {11'd0, done_flag}, 12'd1);

    // R9: failing averaged set is consumed
    avg_sel = 3'd0; cmp_en = 1'b1; cmp_mode = 2'd0; thr_a = 12'd5;
    ack();
    for (int i = 0; i < 4; i++) send(12'd10);
    check("R9 miss flag", {11'd0, done_flag}, 12'd0);
    check("R9 miss result", result, 12'd1550);
    for (int i = 0; i < 4; i++) send(12'd2);
    check("R9 next set result", result, 12'd2);
    check("R9 next set flag", {11'd0, done_flag}, 12'd1);

    // R10 / R11: overwrite control
    avg_sel = 3'd4; cmp_en = 1'b0; ovr_en = 1'b0;
    ack();
    send(12'd500);
    check("R10 first", result, 12'd500);
    send(12'd600);
    check("R10 dropped", result, 12'd500);
    check("R10 flag held", {11'd0, done_flag}, 12'd1);
    ovr_en = 1'b1;
    send(12'd700);
    check("R11 replaced", result, 12'd700);

    // R12: acknowledge, then acknowledge with a coincident commit
    ack();
    check("R12 cleared", {11'd0, done_flag}, 12'd0);
    send(12'd750);
    @(negedge clk);
    flag_ack = 1'b1; raw_valid = 1'b1; raw_data = 12'd800;
    @(negedge clk);
    flag_ack = 1'b0; raw_valid = 1'b0;
    check("R12 commit wins flag", {11'd0, done_flag}, 12'd1);
    check("R12 commit wins result", result, 12'd800);

    // R13: request gating
    dma_en = 1'b0;
    send(12'd900);
    check("R13 off", {11'd0, dma_req}, 12'd0);
    dma_en = 1'b1;
    send(12'd901);
    check("R13 on", {11'd0, dma_req}, 12'd1);
    @(negedge clk);
    check("R13 one cycle", {11'd0, dma_req}, 12'd0);

    finished = 1'b1;
    summary();
  end
endmodule